// File: doc/BRIEF.md
# SPI Configuration Register Port

This block is a serial slave port that gives an external host read and write access to a bank of 32 byte-wide configuration registers. The link can be 3-wire or 4-wire. A transaction runs while the active-low select is held low. It opens with one instruction byte, which sets the direction, how many data bytes follow (one to four) and the register where the burst starts. The data bytes come after it. The register index steps downward after every byte, and it wraps from 0 to 31.

All port pins are brought into the system clock domain through synchronizer chains. The serial clock is sampled at that faster rate, so no logic is clocked by it. Incoming data is taken on rising serial-clock edges. During a read, the next data bit is driven after each falling edge, on the data line and also on the separate output pin when the 4-wire variant is built. The block never has two drivers on the data line: it releases the line when the select goes high, during writes, and while the instruction byte is arriving. The bidirectional pin is split into an input, an output and an output enable, so the pad can sit outside the block. A separate active-low port reset forces the serial engine back to idle.

Top module: `spi_cfg_port`

## Requirements
- R1: The first byte after the select falls is the instruction, received MSB first: bit 7 picks the direction (1 = read, 0 = write), bits 6:5 hold the byte count minus one, and bits 4:0 hold the first register index.
- R2: Write data bytes are received MSB first. Each byte is stored in its register once its eighth bit arrives, and a later read returns it.
- R3: Exactly count+1 data bytes are transferred. Serial clocks that arrive after the last byte change no register.
- R4: Each byte after the first in a burst uses the next lower register index, and index 0 is followed by index 31.
- R5: Read data leaves the block MSB first. Each bit is presented after a falling serial-clock edge and is valid at the rising edge that follows. Bit 7 of the first byte follows the fall after the last instruction bit.
- R6: `sdio_oe` is high only during the data phase of a read. It is low while the instruction is received, for the whole of a write, and within three system clocks after the select goes high.
- R7: If the select goes high in the middle of a byte, the partly received write byte is discarded. The next transaction starts with a fresh instruction byte.
- R8: Holding `port_rst_n` low returns the serial engine to idle and releases the outputs, even while the select is still low.
- R9: With `FOUR_WIRE` = 1, `sdo_o`/`sdo_oe` copy the data-line drive. With `FOUR_WIRE` = 0, `sdo_oe` stays low.
- R10: While `rst` is high, `sdio_oe` and `sdo_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_rst_n | input | 1 | Active-low serial-engine reset (asynchronous pin, synchronized inside) |
| spi_csn | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock, idles low |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, output side |
| sdio_oe | output | 1 | Data line output enable |
| sdo_o | output | 1 | Separate read-data output |
| sdo_oe | output | 1 | Output enable for `sdo_o` |

## Verification
If the register index is wrong, the fault appears as a wrong byte on the data line. It is seen at the first sampled bit of the affected byte of a later read, which is why the bench reads back across the 0-to-31 wrap. If the byte counter or bit counter is out of step, a write lands in a neighbouring register, or a read shifts its data by a bit position. Both show up at the next read-back. If the drive enable is stuck or late, the per-clock monitor catches it within one system clock of the three-clock release window after the select rises. The same monitor catches a drive during the instruction byte or a write.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int LEN_W     = 2;
  localparam int REG_NUM   = 1 << ADDR_W;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INSTR = 2'd1,
    ST_DATA  = 2'd2,
    ST_DONE  = 2'd3
  } xfer_state_t;

  // instruction layout: direction, count-1, start index (MSB to LSB)
  typedef struct packed {
    logic              rd;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  function automatic instr_t instr_decode(input logic [BYTE_W-1:0] b);
    return instr_t'(b);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  // STAGES must be at least 2
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_reg_ram.sv
module spi_reg_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  // R2
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst) !(we && re));
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              prst_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [BYTE_W-1:0] rdata,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic              out_bit,
  output logic              out_en
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  xfer_state_t           state;
  logic                  sclk_d;
  logic [BIT_CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0]     rx_sh;
  logic [BYTE_W-1:0]     tx_sh;
  logic                  rd_mode;
  logic [LEN_W-1:0]      cnt_left;
  logic [ADDR_W-1:0]     addr;
  logic                  load_pend;

  logic        rise, fall, abort, byte_end;
  logic [BYTE_W-1:0] rx_byte;
  instr_t      ins;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign abort    = csn_s | ~prst_n_s;
  assign rx_byte  = {rx_sh, sdi_s};
  assign ins      = instr_decode(rx_byte);
  assign byte_end = rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sclk_d    <= 1'b0;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rd_mode   <= 1'b0;
      cnt_left  <= '0;
      addr      <= '0;
      load_pend <= 1'b0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
      re        <= 1'b0;
      raddr     <= '0;
      out_bit   <= 1'b0;
      out_en    <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      we        <= 1'b0;
      re        <= 1'b0;
      load_pend <= re;
      if (load_pend) tx_sh <= rdata;

      if (abort) begin
        state     <= ST_IDLE;
        bit_cnt   <= '0;
        out_en    <= 1'b0;
        load_pend <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            state   <= ST_INSTR;
            bit_cnt <= '0;
          end
          ST_INSTR: begin
            if (rise) begin
              rx_sh   <= rx_byte[BYTE_W-2:0];
              bit_cnt <= bit_cnt + 1'b1;
              if (byte_end) begin
                rd_mode  <= ins.rd;
                cnt_left <= ins.len;
                addr     <= ins.addr;
                state    <= ST_DATA;
                if (ins.rd) begin
                  re    <= 1'b1;
                  raddr <= ins.addr;
                end
              end
            end
          end
          ST_DATA: begin
            if (rise) begin
              rx_sh   <= rx_byte[BYTE_W-2:0];
              bit_cnt <= bit_cnt + 1'b1;
              if (byte_end) begin
                if (!rd_mode) begin
                  we    <= 1'b1;
                  waddr <= addr;
                  wdata <= rx_byte;
                end
                addr     <= addr - 1'b1;
                cnt_left <= cnt_left - 1'b1;
                if (cnt_left == '0) begin
                  state <= ST_DONE;
                end else if (rd_mode) begin
                  re    <= 1'b1;
                  raddr <= addr - 1'b1;
                end
              end
            end
            if (fall && rd_mode) begin
              out_bit <= tx_sh[BYTE_W-1];
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              out_en  <= 1'b1;
            end
          end
          ST_DONE: begin
            state <= ST_DONE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6
  drive_only_read_chk: assert property (@(posedge clk) disable iff (rst)
    out_en |-> (rd_mode && (state == ST_DATA || state == ST_DONE)));

  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(csn_s) |=> (!out_en && state == ST_IDLE));

  // R2
  write_dir_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> !rd_mode);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!abort && state == ST_DATA && byte_end && cnt_left != '0)
      |=> (addr == $past(addr) - ADDR_W'(1)));

  // R8
  port_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(prst_n_s) |=> (!out_en && state == ST_IDLE));
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit FOUR_WIRE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic port_rst_n,
  input  logic spi_csn,
  input  logic spi_sclk,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  output logic sdo_o,
  output logic sdo_oe
);
  logic csn_s, prst_n_s, sclk_s, sdi_s;
  logic              we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [BYTE_W-1:0] wdata, rdata;
  logic              out_bit, out_en;

  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk(clk), .rst(rst), .d(spi_csn), .q(csn_s));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_prst (
    .clk(clk), .rst(rst), .d(port_rst_n), .q(prst_n_s));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .d(spi_sclk), .q(sclk_s));
  spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst(rst), .d(sdio_i), .q(sdi_s));

  spi_xfer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csn_s(csn_s), .prst_n_s(prst_n_s),
    .sclk_s(sclk_s), .sdi_s(sdi_s), .rdata(rdata),
    .we(we), .waddr(waddr), .wdata(wdata), .re(re), .raddr(raddr),
    .out_bit(out_bit), .out_en(out_en));

  spi_reg_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(rdata));

  assign sdio_o  = out_bit;
  assign sdio_oe = out_en;

  generate
    if (FOUR_WIRE) begin : g_four_wire
      assign sdo_o  = out_bit;
      assign sdo_oe = out_en;
    end else begin : g_three_wire
      assign sdo_o  = 1'b0;
      assign sdo_oe = 1'b0;
    end
  endgenerate

  // R9
  sdo_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    FOUR_WIRE ? (sdo_oe == sdio_oe) : !sdo_oe);
endmodule

// File: tb/spi_cfg_port_test.sv
module spi_cfg_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_rst_n = 1'b1;
  logic spi_csn = 1'b1;
  logic spi_sclk = 1'b0;
  logic sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic t_sdio_o, t_sdio_oe, t_sdo_o, t_sdo_oe;

  always #5 clk = ~clk;

  spi_cfg_port #(.FOUR_WIRE(1'b1)) uut (
    .clk(clk), .rst(rst), .port_rst_n(port_rst_n), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .sdio_i(sdio_i), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe));

  spi_cfg_port #(.FOUR_WIRE(1'b0)) uut3w (
    .clk(clk), .rst(rst), .port_rst_n(port_rst_n), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .sdio_i(sdio_i), .sdio_o(t_sdio_o),
    .sdio_oe(t_sdio_oe), .sdo_o(t_sdo_o), .sdo_oe(t_sdo_oe));

  int checks = 0;
  int errors = 0;
  bit hiz_exp = 1'b1;
  bit done = 1'b0;
  logic [7:0] mdl [32];
  logic [7:0] txb [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  // per-clock model comparison of the drive enables
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (hiz_exp) begin
        chk(sdio_oe == 1'b0, "R6", "sdio_oe while released", sdio_oe, 0);
        chk(sdo_oe == 1'b0, "R9", "sdo_oe while released", sdo_oe, 0);
      end
      chk(t_sdo_oe == 1'b0, "R9", "3-wire sdo_oe", t_sdo_oe, 0);
      chk(t_sdio_oe == sdio_oe, "R9", "3-wire sdio_oe", t_sdio_oe, sdio_oe);
    end
  end

  // rd: direction; nb: bytes; a: start index; stop_bit: abort before this
  // data bit (-1 none); extra: bits clocked past the burst; rst_bit: port reset
  task automatic spi_txn(input bit rd, input int nb, input int a,
                         input int stop_bit, input int extra, input int rst_bit);
    logic [7:0] ins;
    logic [7:0] pat;
    int total;
    pat = 8'hC3;
    ins = {rd, 2'(nb - 1), 5'(a)};   // R1 instruction layout
    total = nb * 8 + extra;
    hiz_exp = 1'b1;
    spi_csn = 1'b0;
    half();
    for (int i = 7; i >= 0; i--) begin
      sdio_i = ins[i];
      half();
      spi_sclk = 1'b1;
      half();
      spi_sclk = 1'b0;
    end
    if (rd) hiz_exp = 1'b0;
    for (int k = 0; k < total; k++) begin
      int idx;
      int bp;
      int ad;
      idx = k / 8;
      bp  = 7 - (k % 8);
      ad  = (a - idx) & 31;
      if (k == stop_bit) break;
      if (k == rst_bit) begin
        port_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        port_rst_n = 1'b1;
        chk(sdio_oe == 1'b0, "R8", "sdio_oe after port reset", sdio_oe, 0);
        repeat (2) @(negedge clk);
        chk(sdio_oe == 1'b0, "R8", "sdio_oe idle after port reset", sdio_oe, 0);
        break;
      end
      if (rd) sdio_i = 1'b0;
      else    sdio_i = (idx < nb) ? txb[idx][bp] : pat[bp];
      half();
      if (rd && idx < nb) begin
        chk(sdio_oe === 1'b1, "R6", "sdio_oe during read", sdio_oe, 1);
        chk(sdio_o === mdl[ad][bp], "R1/R5", "read bit", sdio_o, mdl[ad][bp]);
        chk(sdo_o === mdl[ad][bp] && sdo_oe === 1'b1, "R9", "sdo bit",
            sdo_o, mdl[ad][bp]);
        chk(t_sdio_o === mdl[ad][bp], "R9", "3-wire read bit", t_sdio_o,
            mdl[ad][bp]);
      end
      spi_sclk = 1'b1;
      half();
      spi_sclk = 1'b0;
      if (!rd && (k % 8) == 7 && idx < nb) mdl[ad] = txb[idx];  // R2 commit
    end
    half();
    spi_csn = 1'b1;
    repeat (4) @(negedge clk);
    hiz_exp = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sdio_oe == 1'b0, "R10", "sdio_oe in reset", sdio_oe, 0);
    chk(sdo_oe == 1'b0, "R10", "sdo_oe in reset", sdo_oe, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4: four-byte write from 5 down to 2, then read back
    txb = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    spi_txn(1'b0, 4, 5, -1, 0, -1);
    spi_txn(1'b1, 4, 5, -1, 0, -1);

    // R4: burst across the 0 -> 31 wrap
    txb = '{8'h11, 8'h22, 8'h33, 8'h00};
    spi_txn(1'b0, 3, 1, -1, 0, -1);
    spi_txn(1'b1, 3, 1, -1, 0, -1);
    spi_txn(1'b1, 1, 31, -1, 0, -1);

    // R3: extra clocks after a single-byte write leave register 9 alone
    txb = '{8'h99, 8'h00, 8'h00, 8'h00};
    spi_txn(1'b0, 1, 9, -1, 0, -1);
    txb = '{8'h7E, 8'h00, 8'h00, 8'h00};
    spi_txn(1'b0, 1, 10, -1, 8, -1);
    spi_txn(1'b1, 2, 10, -1, 0, -1);

    // R7: partial write byte discarded on select release
    txb = '{8'h5A, 8'h00, 8'h00, 8'h00};
    spi_txn(1'b0, 1, 20, -1, 0, -1);
    txb = '{8'hFF, 8'h00, 8'h00, 8'h00};
    spi_txn(1'b0, 1, 20, 5, 0, -1);
    spi_txn(1'b1, 1, 20, -1, 0, -1);

    // R6 R7: read aborted mid-byte releases the line
    spi_txn(1'b1, 2, 5, 11, 0, -1);

    // R8: port reset during a read with select still low
    spi_txn(1'b1, 2, 5, -1, 0, 10);

    // R4 R5: read spanning both written groups after the disturbances
    spi_txn(1'b1, 4, 3, -1, 0, -1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule